// File: doc/BRIEF.md
# Multiplexed BCD Seven-Segment Scanner with Zero Suppression

This block drives a row of seven-segment digits one at a time. It takes a packed vector of BCD digits and visits them from the most significant digit to the least significant. Each visited digit is decoded to active-high segments a–g, and a one-hot select picks the physical digit that should light. A prescaler sets how many clocks each digit stays selected. In the first clock after the selection moves, the segments are held dark so the previous glyph does not ghost onto the new digit.

Zero suppression works like a ripple-blanking chain folded into time. A single flag says whether every digit scanned so far in the current pass has been zero. The flag is set at the start of each pass and cleared by the first nonzero code. While the flag is set, a zero digit is blanked. The least significant digit always shows its zero, so a value of zero reads "0". Codes 10 to 15 show nothing, but they still count as significant.

A lamp-test input lights every segment on every digit and overrides zero suppression and dimming. A lit-enable input is meant to carry a PWM waveform: when it is low, every digit goes dark together. Dimming leaves the suppression flag untouched.

Top module: `bcd_scan_display`

## Requirements
- R1: While reset is high and in the first cycle after it falls, `digSel` selects the most significant digit (only bit NUM_DIGITS-1 set) and `segOut` is 0.
- R2: `digSel` is always one-hot. Each digit stays selected for DWELL clocks. The order is digit NUM_DIGITS-1 down to digit 0, then back to NUM_DIGITS-1.
- R3: In the first clock after `digSel` changes, `segOut` is 0. This holds even during lamp test.
- R4: `segOut` is bit 6 = a down to bit 0 = g, and 1 lights a segment. The digit codes map as follows: 0=7E, 1=30, 2=6D, 3=79, 4=33, 5=5B, 6=1F (no top bar), 7=70, 8=7F, 9=73 (no bottom bar). Digit i is `digitsIn[4i+3:4i]`.
- R5: A selected digit with code 10 to 15 shows `segOut`=0 and counts as a significant digit for the digits below it.
- R6: A zero digit is blanked when every higher digit in the current pass is zero.
- R7: Digit 0 shows the zero glyph (7E) when its code is 0, even when every higher digit is zero.
- R8: When `lampTest` is 1 outside the R3 gap cycle, `segOut` is 7F whatever the codes and `litEn` are.
- R9: When `litEn` is 0 and `lampTest` is 0, `segOut` is 0. Dimming does not change which zeros are suppressed once `litEn` returns to 1.
- R10: A zero digit below a significant digit shows the zero glyph (7E).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| digitsIn | input | 4*NUM_DIGITS | Packed BCD digits; nibble i is digit i, and the highest nibble is most significant |
| lampTest | input | 1 | 1 lights all segments |
| litEn | input | 1 | Intensity / blanking; 0 darkens all digits |
| segOut | output | 7 | Segments a..g (bit 6 = a), active high |
| digSel | output | NUM_DIGITS | One-hot select of the digit being shown |

## Verification
Lamp test and the anti-ghost blank can fall in the same clock. Lamp test must win everywhere except the first clock after the selection moves, where the blank wins. The bench holds lamp test high across whole passes and also toggles it at random cycles, so both cases are hit. It judges each clock against a model that places the gap cycle from its own count of clocks since reset. Dimming pulses in the middle of a pass are checked in the same way: a zero after a significant digit must reappear as soon as the enable returns.

// File: rtl/bcd_scan_pkg.sv
package bcd_scan_pkg;

  typedef struct packed {
    logic step;   // selection moves at the next edge
    logic wrap;   // this step returns to the most significant digit
    logic quiet;  // first clock of a new selection
  } scan_strobe_t;

  localparam logic [6:0] SEG_NONE = 7'h00;
  localparam logic [6:0] SEG_FULL = 7'h7F;

  // a..g on bits 6..0; codes above 9 give a dark digit
  function automatic logic [6:0] bcdGlyph(input logic [3:0] code);
    logic [6:0] g;
    case (code)
      4'd0:    g = 7'b1111110;
      4'd1:    g = 7'b0110000;
      4'd2:    g = 7'b1101101;
      4'd3:    g = 7'b1111001;
      4'd4:    g = 7'b0110011;
      4'd5:    g = 7'b1011011;
      4'd6:    g = 7'b0011111;
      4'd7:    g = 7'b1110000;
      4'd8:    g = 7'b1111111;
      4'd9:    g = 7'b1110011;
      default: g = SEG_NONE;
    endcase
    return g;
  endfunction

endpackage

// File: rtl/bcd_scan_ctrl.sv
module bcd_scan_ctrl
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int DWELL      = 4,
  parameter int IW         = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  output logic [IW-1:0]         curIdx,
  output logic [NUM_DIGITS-1:0] digSel,
  output scan_strobe_t          strobe
);

  localparam int CW = (DWELL > 1) ? $clog2(DWELL) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(DWELL - 1);
  localparam logic [IW-1:0] IDX_TOP  = IW'(NUM_DIGITS - 1);

  logic [CW-1:0] dwellCnt;
  logic          quietQ;
  logic          stepNow;
  logic          wrapNow;

  assign stepNow = (dwellCnt == CNT_LAST);
  assign wrapNow = stepNow && (curIdx == '0);

  // R2: dwell counter and descending digit index
  always_ff @(posedge clk) begin
    if (rst) begin
      dwellCnt <= '0;
      curIdx   <= IDX_TOP;
      quietQ   <= 1'b1;
    end else begin
      quietQ <= stepNow;
      if (stepNow) begin
        dwellCnt <= '0;
        curIdx   <= wrapNow ? IDX_TOP : curIdx - IW'(1);
      end else begin
        dwellCnt <= dwellCnt + CW'(1);
      end
    end
  end

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_sel
    assign digSel[i] = (curIdx == IW'(i));
  end

  assign strobe.step  = stepNow;
  assign strobe.wrap  = wrapNow;
  assign strobe.quiet = quietQ;

endmodule

// File: rtl/bcd_scan_datapath.sv
module bcd_scan_datapath
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int IW         = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4*NUM_DIGITS-1:0] digitsIn,
  input  logic                    lampTest,
  input  logic                    litEn,
  input  logic [IW-1:0]           curIdx,
  input  scan_strobe_t            strobe,
  output logic [6:0]              segOut
);

  logic [3:0] curCode;
  logic       leadQ;     // every digit so far in this pass was zero
  logic       lastDigit;
  logic       hideZero;

  assign curCode   = digitsIn[{curIdx, 2'b00} +: 4];
  assign lastDigit = (curIdx == '0);
  assign hideZero  = (curCode == 4'd0) && leadQ && !lastDigit;

  // R6 / R10: the flag carries the ripple-blank state between digits
  always_ff @(posedge clk) begin
    if (rst) begin
      leadQ <= 1'b1;
    end else if (strobe.step) begin
      leadQ <= strobe.wrap ? 1'b1 : (leadQ && (curCode == 4'd0));
    end
  end

  // priority: gap blank, lamp test, dimming, suppression, glyph
  always_comb begin
    if (strobe.quiet) begin
      segOut = SEG_NONE;
    end else if (lampTest) begin
      segOut = SEG_FULL;
    end else if (!litEn || hideZero) begin
      segOut = SEG_NONE;
    end else begin
      segOut = bcdGlyph(curCode);
    end
  end

endmodule

// File: rtl/bcd_scan_display.sv
module bcd_scan_display
  import bcd_scan_pkg::*;
#(
  parameter int NUM_DIGITS = 4,
  parameter int DWELL      = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [4*NUM_DIGITS-1:0] digitsIn,
  input  logic                    lampTest,
  input  logic                    litEn,
  output logic [6:0]              segOut,
  output logic [NUM_DIGITS-1:0]   digSel
);

  localparam int IW = (NUM_DIGITS > 1) ? $clog2(NUM_DIGITS) : 1;

  logic [IW-1:0] curIdx;
  scan_strobe_t  strobe;

  bcd_scan_ctrl #(
    .NUM_DIGITS(NUM_DIGITS),
    .DWELL     (DWELL),
    .IW        (IW)
  ) ctrl_i (
    .clk   (clk),
    .rst   (rst),
    .curIdx(curIdx),
    .digSel(digSel),
    .strobe(strobe)
  );

  bcd_scan_datapath #(
    .NUM_DIGITS(NUM_DIGITS),
    .IW        (IW)
  ) dp_i (
    .clk     (clk),
    .rst     (rst),
    .digitsIn(digitsIn),
    .lampTest(lampTest),
    .litEn   (litEn),
    .curIdx  (curIdx),
    .strobe  (strobe),
    .segOut  (segOut)
  );

endmodule

// File: rtl/bcd_scan_chk.sv
module bcd_scan_chk #(
  parameter int NUM_DIGITS = 4
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  lampTest,
  input logic                  litEn,
  input logic [6:0]            segOut,
  input logic [NUM_DIGITS-1:0] digSel
);

  localparam logic [NUM_DIGITS-1:0] TOP_SEL = NUM_DIGITS'(1) << (NUM_DIGITS - 1);

  // R2
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(digSel) == 1);

  // R1
  reset_top_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (digSel == TOP_SEL) && (segOut == 7'h00));

  // R3
  gap_blank_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(digSel) |-> segOut == 7'h00);

  // R8
  lamp_full_chk: assert property (@(posedge clk) disable iff (rst)
    (lampTest && $stable(digSel) && !$past(rst)) |-> segOut == 7'h7F);

  // R9
  dim_dark_chk: assert property (@(posedge clk) disable iff (rst)
    (!litEn && !lampTest) |-> segOut == 7'h00);

endmodule

bind bcd_scan_display bcd_scan_chk #(.NUM_DIGITS(NUM_DIGITS)) chk_i (
  .clk     (clk),
  .rst     (rst),
  .lampTest(lampTest),
  .litEn   (litEn),
  .segOut  (segOut),
  .digSel  (digSel)
);

// File: tb/bcd_scan_display_tb_top.sv
`timescale 1ns/1ps
module bcd_scan_display_tb_top;

  localparam int N = 4;
  localparam int D = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [4*N-1:0] digitsIn = '0;
  logic         lampTest = 1'b0;
  logic         litEn = 1'b1;
  logic [6:0]   segOut;
  logic [N-1:0] digSel;

  int total = 0;
  int bad = 0;
  int tick = 0;
  bit done = 0;

  always #4 clk = ~clk;

  always @(posedge clk) tick <= rst ? 0 : tick + 1;

  bcd_scan_display #(.NUM_DIGITS(N), .DWELL(D)) dut_i (
    .clk(clk), .rst(rst), .digitsIn(digitsIn), .lampTest(lampTest),
    .litEn(litEn), .segOut(segOut), .digSel(digSel)
  );

  function automatic logic [6:0] refGlyph(input logic [3:0] c);
    case (c)
      4'd0: return 7'h7E; 4'd1: return 7'h30; 4'd2: return 7'h6D;
      4'd3: return 7'h79; 4'd4: return 7'h33; 4'd5: return 7'h5B;
      4'd6: return 7'h1F; 4'd7: return 7'h70; 4'd8: return 7'h7F;
      4'd9: return 7'h73; default: return 7'h00;
    endcase
  endfunction

  function automatic void model(input logic [4*N-1:0] dig, input bit lt, input bit lit,
                                input int t, output logic [6:0] seg,
                                output logic [N-1:0] sel, output string tag);
    int idx;
    logic [3:0] code;
    bit lead;
    idx  = N - 1 - ((t / D) % N);
    code = dig[idx*4 +: 4];
    lead = 1;
    for (int j = N - 1; j > idx; j--) if (dig[j*4 +: 4] != 4'd0) lead = 0;
    sel = N'(1) << idx;
    if (t % D == 0)                    begin seg = 7'h00;          tag = "R3";  end
    else if (lt)                       begin seg = 7'h7F;          tag = "R8";  end
    else if (!lit)                     begin seg = 7'h00;          tag = "R9";  end
    else if (code > 4'd9)              begin seg = 7'h00;          tag = "R5";  end
    else if (code == 0 && idx == 0)    begin seg = 7'h7E;          tag = "R7";  end
    else if (code == 0 && lead)        begin seg = 7'h00;          tag = "R6";  end
    else if (code == 0)                begin seg = 7'h7E;          tag = "R10"; end
    else                               begin seg = refGlyph(code); tag = "R4";  end
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h tick=%0d", req, act, exp, tick);
    end
  endtask

  // mode: 0 lit, 1 lamp test, 2 dark, 3 random controls per clock
  task automatic runScan(input logic [4*N-1:0] dig, input int mode);
    logic [6:0] eSeg;
    logic [N-1:0] eSel;
    string tag;
    digitsIn = dig;
    for (int c = 0; c < N * D; c++) begin
      case (mode)
        0: begin lampTest = 0; litEn = 1; end
        1: begin lampTest = 1; litEn = ($urandom % 2) == 0; end
        2: begin lampTest = 0; litEn = 0; end
        default: begin lampTest = ($urandom % 8) == 0; litEn = ($urandom % 5) != 0; end
      endcase
      #1;
      model(dig, lampTest, litEn, tick, eSeg, eSel, tag);
      check(tag, 32'(segOut), 32'(eSeg));
      check("R2", 32'(digSel), 32'(eSel));
      @(negedge clk);
    end
  endtask

  function automatic logic [4*N-1:0] randDigits();
    logic [4*N-1:0] v;
    for (int k = 0; k < N; k++) begin
      int r;
      r = $urandom % 8;
      if (r < 3)       v[k*4 +: 4] = 4'd0;
      else if (r == 7) v[k*4 +: 4] = 4'(10 + $urandom % 6);
      else             v[k*4 +: 4] = 4'($urandom % 10);
    end
    return v;
  endfunction

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check("R1", 32'(digSel), 32'(N'(1) << (N - 1)));
    check("R1", 32'(segOut), 32'h0);
    lampTest = 1;
    #1;
    check("R3", 32'(segOut), 32'h0);
    lampTest = 0;
    rst = 0;
    // directed passes
    runScan(16'h0000, 0);  // R7, R6
    runScan(16'h0007, 0);  // R6, R4
    runScan(16'h0103, 0);  // R10
    runScan(16'h00A0, 0);  // R5
    runScan(16'hF000, 0);  // R5 then R10
    runScan(16'h9876, 0);  // R4
    runScan(16'h5432, 0);  // R4
    runScan(16'h1000, 0);  // R10
    runScan(16'h00A0, 1);  // R8 vs R3
    runScan(16'h1203, 2);  // R9
    runScan(16'h1203, 3);  // R9 mid-pass recovery
    for (int s = 0; s < 80; s++) runScan(randDigits(), 3);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule